// File: doc/BRIEF.md
# Conversion Result Limit Watcher with Hysteresis

This block watches the stream of 12-bit results from one converter channel. A host programs an upper bound, a lower bound and a hysteresis amount N over a small address/data write port. When a result crosses a bound, the block emits a one-cycle event pulse on the matching side. That side then stays quiet until a later result has moved back inside the bound by more than N. This keeps a noisy signal near a threshold from producing a stream of repeated events. The pulses are meant to feed an alert status register that lives outside this block.

When the hysteresis register holds its all-ones code, the two bound registers stop acting as thresholds. Instead they track the largest and smallest result seen since they were last written. No events are produced in this mode. A host that wants a fresh span writes the upper register to zero and the lower register to full scale, then reads both back later over the combinational read port.

Top module: `limit_watch`

## Requirements
- R1: After reset, address 0 (upper bound) reads 0x0FFF, address 1 (lower bound) reads 0x0000 and address 2 (hysteresis) reads 0x0008. Both event outputs are low.
- R2: Writes to address 0, 1 and 2 store bits 11:0 of the write data. Every read returns a 16-bit word whose bits 15:12 are zero. Address 3 always reads 0x0000.
- R3: With the parameter LOW_RES set to 1, the hysteresis register resets to 0x0002 and always holds bits 1:0 at zero. Its all-ones code becomes 0xFFC.
- R4: A valid result strictly greater than the upper bound, with the upper side armed, raises `violHi` in the cycle after the strobe for exactly one cycle and disarms the upper side. A result equal to the bound raises nothing.
- R5: A valid result strictly less than the lower bound, with the lower side armed, raises `violLo` in the cycle after the strobe for exactly one cycle and disarms the lower side.
- R6: A disarmed upper side re-arms only on a valid result strictly less than the upper bound minus N. A result equal to that value does not re-arm it.
- R7: A disarmed lower side re-arms only on a valid result strictly greater than the lower bound plus N.
- R8: The value bound minus N is floored at 0, and the value bound plus N is capped at 0xFFF, so neither wraps around.
- R9: Results are compared only in a cycle with `sampleValid` high. Data presented without the strobe changes no state and produces no event.
- R10: While the hysteresis register holds its all-ones code, each valid result larger than the upper register replaces it and each valid result smaller than the lower register replaces it. No event is raised.
- R11: A host write to a bound register in the same cycle as a capture update wins: the written value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address (0 upper, 1 lower, 2 hysteresis) |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address, combinational read |
| rdData | output | 16 | Read data, upper bits zero |
| sampleValid | input | 1 | Conversion result strobe |
| sampleData | input | 12 | Conversion result |
| violHi | output | 1 | One-cycle upper-bound event pulse |
| violLo | output | 1 | One-cycle lower-bound event pulse |

## Verification
Register writes and result strobes take effect on the rising edge where they are sampled. The event pulses are therefore visible just after that edge and must be gone one edge later. `rdData` follows `rdAddr` with no clock, so readback reflects the registers as they stand after the last edge. The bench drives inputs on falling edges and checks each result one time unit after the rising edge where it is due. It checks the pulse again after the following rising edge to confirm that the pulse is low.

// File: rtl/limit_watch_pkg.sv
package limit_watch_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HYST = 2'd2;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic wrHyst;
    logic capture;  // valid result in min/max mode
    logic cmpEn;    // valid result in threshold mode
  } strobes_t;
endpackage

// File: rtl/limit_watch_ctrl.sv
module limit_watch_ctrl
  import limit_watch_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              sampleValid,
  input  logic              captureMode,
  output strobes_t          strobes
);
  always_comb begin
    strobes         = '0;
    strobes.wrHi    = wrEn && (wrAddr == ADDR_HI);
    strobes.wrLo    = wrEn && (wrAddr == ADDR_LO);
    strobes.wrHyst  = wrEn && (wrAddr == ADDR_HYST);
    strobes.capture = sampleValid && captureMode;
    strobes.cmpEn   = sampleValid && !captureMode;
  end
endmodule

// File: rtl/limit_watch_dp.sv
module limit_watch_dp
  import limit_watch_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int REG_W   = 16,
  parameter bit LOW_RES = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic [DATA_W-1:0] sampleData,
  output logic              captureMode,
  output logic              violHi,
  output logic              violLo
);
  localparam logic [DATA_W-1:0] FULL      = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] HYST_MASK = LOW_RES ? (FULL & ~DATA_W'(3)) : FULL;
  localparam logic [DATA_W-1:0] HYST_RST  = LOW_RES ? DATA_W'(2) : DATA_W'(8);
  localparam int PAD_W = REG_W - DATA_W;

  logic [DATA_W-1:0] hiLim, loLim, hystVal;
  logic [DATA_W-1:0] hiFloor, loCeil;
  logic [DATA_W:0]   loSum;
  logic              hiArmed, loArmed;
  logic [DATA_W-1:0] wrVal;

  assign wrVal       = wrData[DATA_W-1:0];
  assign captureMode = (hystVal == HYST_MASK);

  // Saturating re-arm thresholds
  assign hiFloor = (hiLim > hystVal) ? (hiLim - hystVal) : '0;
  assign loSum   = {1'b0, loLim} + {1'b0, hystVal};
  assign loCeil  = loSum[DATA_W] ? FULL : loSum[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hystVal <= HYST_RST;
    end else if (strobes.wrHyst) begin
      hystVal <= wrVal & HYST_MASK;
    end
  end

  // Bound registers: host write has priority over capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiLim <= FULL;
      loLim <= '0;
    end else begin
      if (strobes.wrHi)
        hiLim <= wrVal;
      else if (strobes.capture && (sampleData > hiLim))
        hiLim <= sampleData;
      if (strobes.wrLo)
        loLim <= wrVal;
      else if (strobes.capture && (sampleData < loLim))
        loLim <= sampleData;
    end
  end

  // Arm flags and event pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiArmed <= 1'b1;
      loArmed <= 1'b1;
      violHi  <= 1'b0;
      violLo  <= 1'b0;
    end else begin
      violHi <= 1'b0;
      violLo <= 1'b0;
      if (strobes.cmpEn) begin
        if (hiArmed && (sampleData > hiLim)) begin
          violHi  <= 1'b1;
          hiArmed <= 1'b0;
        end else if (!hiArmed && (sampleData < hiFloor)) begin
          hiArmed <= 1'b1;
        end
        if (loArmed && (sampleData < loLim)) begin
          violLo  <= 1'b1;
          loArmed <= 1'b0;
        end else if (!loArmed && (sampleData > loCeil)) begin
          loArmed <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_HI:   rdData = {{PAD_W{1'b0}}, hiLim};
      ADDR_LO:   rdData = {{PAD_W{1'b0}}, loLim};
      ADDR_HYST: rdData = {{PAD_W{1'b0}}, hystVal};
      default:   rdData = '0;
    endcase
  end

  AST_HI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    violHi |=> !violHi); // R4
  AST_LO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    violLo |=> !violLo); // R5
  AST_EVENT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (violHi || violLo) |-> $past(strobes.cmpEn)); // R9
  AST_CAPTURE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (!violHi && !violLo)); // R10
  AST_CAPTURE_HI_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !strobes.wrHi) |=> (hiLim >= $past(hiLim))); // R10
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrHi |=> (hiLim == $past(wrVal))); // R11
endmodule

// File: rtl/limit_watch.sv
module limit_watch
  import limit_watch_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int REG_W   = 16,
  parameter bit LOW_RES = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic              violHi,
  output logic              violLo
);
  strobes_t strobes;
  logic     captureMode;

  limit_watch_ctrl u_ctrl (
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .sampleValid (sampleValid),
    .captureMode (captureMode),
    .strobes     (strobes)
  );

  limit_watch_dp #(
    .DATA_W  (DATA_W),
    .REG_W   (REG_W),
    .LOW_RES (LOW_RES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .sampleData  (sampleData),
    .captureMode (captureMode),
    .violHi      (violHi),
    .violLo      (violLo)
  );
endmodule

// File: tb/limit_watch_tb.sv
module limit_watch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic [15:0] rdData, rdDataRed;
  logic        violHi, violLo, violHiRed, violLoRed;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limit_watch u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sampleValid(sampleValid),
    .sampleData(sampleData), .violHi(violHi), .violLo(violLo)
  );

  limit_watch #(.LOW_RES(1'b1)) u_dutRed (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdDataRed), .sampleValid(sampleValid),
    .sampleData(sampleData), .violHi(violHiRed), .violLo(violLoRed)
  );

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; sampleValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input string req, input logic [1:0] a, input logic [15:0] exp);
    rdAddr = a;
    #1;
    check(req, $sformatf("read addr %0d", a), rdData, exp);
  endtask

  // One strobed result; pulse due right after the sampling edge, gone one edge later
  task automatic strobe(input string req, input logic [11:0] d,
                        input logic expHi, input logic expLo);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = d;
    @(posedge clk); #1;
    check(req, $sformatf("violHi after %0d", d), {15'b0, violHi}, {15'b0, expHi});
    check(req, $sformatf("violLo after %0d", d), {15'b0, violLo}, {15'b0, expLo});
    @(negedge clk);
    sampleValid = 1'b0;
    @(posedge clk); #1;
    check(req, "pulse width", {14'b0, violHi, violLo}, 16'h0);
  endtask

  task automatic testReset();
    doReset();
    regRead("R1", 2'd0, 16'h0FFF);
    regRead("R1", 2'd1, 16'h0000);
    regRead("R1", 2'd2, 16'h0008);
    check("R1", "events idle", {14'b0, violHi, violLo}, 16'h0);
  endtask

  task automatic testRegMap();
    regWrite(2'd2, 16'hF123);
    regRead("R2", 2'd2, 16'h0123);
    regWrite(2'd0, 16'hA456);
    regRead("R2", 2'd0, 16'h0456);
    regRead("R2", 2'd3, 16'h0000);
  endtask

  task automatic testReducedRes();
    doReset();
    rdAddr = 2'd2; #1;
    check("R3", "reduced reset hyst", rdDataRed, 16'h0002);
    regWrite(2'd2, 16'h00FF);
    rdAddr = 2'd2; #1;
    check("R3", "reduced low bits forced", rdDataRed, 16'h00FC);
    regWrite(2'd2, 16'hFFFF);
    regWrite(2'd0, 16'h0000);
    strobe("R3", 12'd77, 1'b0, 1'b0);
    rdAddr = 2'd0; #1;
    check("R3", "reduced all-ones enables capture", rdDataRed, 16'd77);
  endtask

  task automatic testNoStrobe();
    doReset();
    regWrite(2'd0, 16'd1000);
    regWrite(2'd1, 16'd200);
    @(negedge clk);
    sampleData = 12'd4000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      check("R9", "no event without strobe", {14'b0, violHi, violLo}, 16'h0);
    end
    sampleData = 12'd0;
    @(posedge clk); #1;
    check("R9", "no low event without strobe", {14'b0, violHi, violLo}, 16'h0);
  endtask

  task automatic testHigh();
    strobe("R4", 12'd1000, 1'b0, 1'b0);
    strobe("R4", 12'd1001, 1'b1, 1'b0);
    strobe("R6", 12'd1500, 1'b0, 1'b0);
    strobe("R6", 12'd992,  1'b0, 1'b0);
    strobe("R6", 12'd1500, 1'b0, 1'b0);
    strobe("R6", 12'd991,  1'b0, 1'b0);
    strobe("R6", 12'd1001, 1'b1, 1'b0);
  endtask

  task automatic testLow();
    strobe("R5", 12'd200, 1'b0, 1'b0);
    strobe("R5", 12'd199, 1'b0, 1'b1);
    strobe("R7", 12'd208, 1'b0, 1'b0);
    strobe("R7", 12'd150, 1'b0, 1'b0);
    strobe("R7", 12'd209, 1'b0, 1'b0);
    strobe("R7", 12'd100, 1'b0, 1'b1);
  endtask

  task automatic testSaturation();
    doReset();
    regWrite(2'd0, 16'd4);
    strobe("R8", 12'd5, 1'b1, 1'b0);
    strobe("R8", 12'd0, 1'b0, 1'b0);
    strobe("R8", 12'd5, 1'b0, 1'b0);
    regWrite(2'd1, 16'd4090);
    strobe("R8", 12'd4000, 1'b0, 1'b1);
    strobe("R8", 12'd4095, 1'b0, 1'b0);
    strobe("R8", 12'd4000, 1'b0, 1'b0);
  endtask

  task automatic testCapture();
    doReset();
    regWrite(2'd2, 16'hFFFF);
    regRead("R10", 2'd2, 16'h0FFF);
    regWrite(2'd0, 16'h0000);
    regWrite(2'd1, 16'h0FFF);
    strobe("R10", 12'd100, 1'b0, 1'b0);
    strobe("R10", 12'd50,  1'b0, 1'b0);
    strobe("R10", 12'd300, 1'b0, 1'b0);
    regRead("R10", 2'd0, 16'd300);
    regRead("R10", 2'd1, 16'd50);
  endtask

  task automatic testWriteWins();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'd10;
    sampleValid = 1'b1; sampleData = 12'd999;
    @(negedge clk);
    wrEn = 1'b0; sampleValid = 1'b0;
    regRead("R11", 2'd0, 16'd10);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testReset();
    testRegMap();
    testReducedRes();
    testNoStrobe();
    testHigh();
    testLow();
    testSaturation();
    testCapture();
    testWriteWins();
    finishRun();
  end
endmodule